// File: doc/BRIEF.md
# Mixed-Radix Prefix Adder

A purely combinational two-operand binary adder. It returns an N-bit sum and a carry-out for two N-bit operands and a carry-in, where N is 16 or 32 and is chosen by a parameter. The carries are not rippled. A prefix tree computes the carry into every bit position in a number of cell levels that grows with the logarithm of the width.

The tree has two kinds of level. The first level gathers each position with its two lower neighbours through three-input combine cells, so every entry already covers three positions. Each later level doubles that span with two-input cells, in the regular all-positions pattern of a Kogge-Stone tree. The carry-in enters as the generate term of an extra position below bit 0. Every prefix that reaches that position is therefore already a finished carry. Cells that produce such a prefix are built in a reduced form that yields only a generate term. Every cell is a small tree of 2:1 multiplexers rather than an AND-OR gate pair. The last stage forms each sum bit from that bit's propagate term and its incoming carry.

The block is meant to sit inside a larger datapath that registers its inputs and outputs as needed.

Top module: `hpa_adder`

## Requirements
- R1: For every operand pair and carry-in, {carry_out, sum} equals op_a + op_b + carry_in evaluated in W+1 bits, for W = 16 and for W = 32.
- R2: Bit 0 of sum equals op_a[0] XOR op_b[0] XOR carry_in, whatever the upper bits hold.
- R3: When every bit position propagates (op_a XOR op_b is all ones), the carry-in travels through the whole width: sum is all ones and carry_out is 0 when carry_in is 0, and sum is 0 and carry_out is 1 when carry_in is 1.
- R4: With both operands zero, sum equals carry_in zero-extended and carry_out is 0.
- R5: With both operands all ones, carry_out is 1 and sum is all ones except bit 0, which equals carry_in.
- R6: When the most significant bit of both operands is 1, carry_out is 1.
- R7: A carry generated at any single bit position k (op_a = 1 shifted left by k, op_b = all ones shifted left by k) propagates to every higher position, giving sum 0 and carry_out 1 for every k from 0 to W-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | W | Sum bits |
| carry_out | output | 1 | Carry out of the most significant bit |

## Verification
Zero operands and all-ones operands bound the two extremes: one makes no carry at all, and the other generates a carry at every bit. Patterns in which every bit propagates include all-ones plus one and the alternating 0101/1010 pair. They force the carry-in along the longest path, so they expose a tree entry whose span misses position 0 or a reduced cell on a wrong path. A sweep of a single generate position k across the width, with propagation above it, exercises each distinct route through the radix-3 level and each doubling level. Random vectors and a sweep over the lowest bit with the carry-in cover the remaining mixes of generate, propagate and kill. Every pattern is applied to a 16-bit copy and a 32-bit copy of the block.

// File: rtl/hpa_pkg.sv
package hpa_pkg;

    // Number of doubling levels that follow the radix-3 level so that a
    // span starting at 3 positions covers n_pos positions.
    function automatic int tree_levels(int n_pos);
        int lv;
        int span;
        lv   = 0;
        span = 3;
        while (span < n_pos) begin
            span = span * 2;
            lv   = lv + 1;
        end
        return lv;
    endfunction

    // Mux-form combines. They rely on g and p never being 1 together,
    // which holds for per-bit (a&b, a^b) terms and for every group built from them.
    function automatic logic mux_gen2(logic g_hi, logic p_hi, logic g_lo);
        return p_hi ? g_lo : g_hi;
    endfunction

    function automatic logic mux_prop2(logic p_hi, logic p_lo);
        return p_hi ? p_lo : 1'b0;
    endfunction

    function automatic logic mux_gen3(logic g_i, logic p_i, logic g_j, logic p_j, logic g_k);
        return p_i ? (p_j ? g_k : g_j) : g_i;
    endfunction

    function automatic logic mux_prop3(logic p_i, logic p_j, logic p_k);
        return p_i ? (p_j ? p_k : 1'b0) : 1'b0;
    endfunction

endpackage

// File: rtl/hpa_cells.sv
// Two-input combine producing group generate and propagate.
module hpa_cell2 (
    input  logic g_hi,
    input  logic p_hi,
    input  logic g_lo,
    input  logic p_lo,
    output logic g_out,
    output logic p_out
);
    import hpa_pkg::*;
    assign g_out = mux_gen2(g_hi, p_hi, g_lo);
    assign p_out = mux_prop2(p_hi, p_lo);
endmodule

// Two-input combine producing the group generate only.
module hpa_cell2g (
    input  logic g_hi,
    input  logic p_hi,
    input  logic g_lo,
    output logic g_out
);
    import hpa_pkg::*;
    assign g_out = mux_gen2(g_hi, p_hi, g_lo);
endmodule

// Three-input combine, inputs ordered i (most significant) to k (least).
module hpa_cell3 (
    input  logic g_i,
    input  logic p_i,
    input  logic g_j,
    input  logic p_j,
    input  logic g_k,
    input  logic p_k,
    output logic g_out,
    output logic p_out
);
    import hpa_pkg::*;
    assign g_out = mux_gen3(g_i, p_i, g_j, p_j, g_k);
    assign p_out = mux_prop3(p_i, p_j, p_k);
endmodule

// Three-input combine producing the group generate only.
module hpa_cell3g (
    input  logic g_i,
    input  logic p_i,
    input  logic g_j,
    input  logic p_j,
    input  logic g_k,
    output logic g_out
);
    import hpa_pkg::*;
    assign g_out = mux_gen3(g_i, p_i, g_j, p_j, g_k);
endmodule

// File: rtl/hpa_pg.sv
// Per-position generate/propagate. Position 0 carries the carry-in as a
// generate with no propagate; position i+1 is operand bit i.
module hpa_pg #(
    parameter int W = 32
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         carry_in,
    output logic [W:0]   pos_g,
    output logic [W:1]   pos_p
);
    assign pos_g = {op_a & op_b, carry_in};
    assign pos_p = op_a ^ op_b;
endmodule

// File: rtl/hpa_tree.sv
// Mixed-radix prefix tree: a radix-3 first level, then doubling levels.
// grp_g[j] is the generate of positions 0..j, i.e. the carry into bit j
// (and grp_g[W] is the carry out).
module hpa_tree #(
    parameter int W = 32
) (
    input  logic [W:0] pos_g,
    input  logic [W:1] pos_p,
    output logic [W:0] grp_g
);
    import hpa_pkg::*;

    localparam int NPOS = W + 1;
    localparam int L    = tree_levels(NPOS);

    for (genvar l = 0; l <= L; l++) begin : lv
        localparam int S = 3 * (2 ** l);                    // span after this level
        localparam int D = (l == 0) ? 0 : 3 * (2 ** (l - 1)); // combine distance
        logic [W:0] g;
        // Propagate is kept only for entries whose span stops short of position 0.
        if (S <= W) begin : hp
            logic [W:S] p;
        end
        for (genvar j = 0; j <= W; j++) begin : ent
            if (l == 0) begin : r3
                if (j == 0) begin : pass
                    assign g[0] = pos_g[0];
                end else if (j == 1) begin : c2g
                    hpa_cell2g u_c (.g_hi(pos_g[1]), .p_hi(pos_p[1]), .g_lo(pos_g[0]), .g_out(g[1]));
                end else if (j == 2) begin : c3g
                    hpa_cell3g u_c (.g_i(pos_g[2]), .p_i(pos_p[2]), .g_j(pos_g[1]), .p_j(pos_p[1]),
                                    .g_k(pos_g[0]), .g_out(g[2]));
                end else begin : c3
                    hpa_cell3 u_c (.g_i(pos_g[j]), .p_i(pos_p[j]), .g_j(pos_g[j-1]), .p_j(pos_p[j-1]),
                                   .g_k(pos_g[j-2]), .p_k(pos_p[j-2]), .g_out(g[j]), .p_out(hp.p[j]));
                end
            end else begin : r2
                if (j < D) begin : pass
                    assign g[j] = lv[l-1].g[j];
                end else if (j >= S) begin : c2
                    hpa_cell2 u_c (.g_hi(lv[l-1].g[j]), .p_hi(lv[l-1].hp.p[j]),
                                   .g_lo(lv[l-1].g[j-D]), .p_lo(lv[l-1].hp.p[j-D]),
                                   .g_out(g[j]), .p_out(hp.p[j]));
                end else begin : c2g
                    hpa_cell2g u_c (.g_hi(lv[l-1].g[j]), .p_hi(lv[l-1].hp.p[j]),
                                    .g_lo(lv[l-1].g[j-D]), .g_out(g[j]));
                end
            end
        end
    end

    assign grp_g = lv[L].g;
endmodule

// File: rtl/hpa_adder.sv
module hpa_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         carry_in,
    output logic [W-1:0] sum,
    output logic         carry_out
);
    logic [W:0] pos_g;
    logic [W:1] pos_p;
    logic [W:0] grp_g;

    hpa_pg #(.W(W)) u_pg (
        .op_a     (op_a),
        .op_b     (op_b),
        .carry_in (carry_in),
        .pos_g    (pos_g),
        .pos_p    (pos_p)
    );

    hpa_tree #(.W(W)) u_tree (
        .pos_g (pos_g),
        .pos_p (pos_p),
        .grp_g (grp_g)
    );

    assign sum       = pos_p ^ grp_g[W-1:0];
    assign carry_out = grp_g[W];
endmodule

// File: rtl/hpa_adder_chk.sv
module hpa_adder_chk #(
    parameter int W = 32
) (
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         carry_in,
    input logic [W-1:0] sum,
    input logic         carry_out
);
    logic [W:0] wide_total;
    assign wide_total = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, carry_in};

    always_comb begin
        p_total_r1: assert ({carry_out, sum} == wide_total);
        p_lsb_r2: assert (sum[0] == (op_a[0] ^ op_b[0] ^ carry_in));
        if ((op_a ^ op_b) == {W{1'b1}}) begin
            p_full_prop_r3: assert ({carry_out, sum} == {carry_in, {W{~carry_in}}});
        end
        if (op_a == '0 && op_b == '0) begin
            p_zero_ops_r4: assert (!carry_out && sum == {{(W-1){1'b0}}, carry_in});
        end
        if (op_a[W-1] && op_b[W-1]) begin
            p_top_gen_r6: assert (carry_out);
        end
    end
endmodule

bind hpa_adder hpa_adder_chk #(.W(W)) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum       (sum),
    .carry_out (carry_out)
);

// File: tb/hpa_adder_test.sv
module hpa_adder_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [31:0] a32, b32, s32;
    logic [15:0] a16, b16, s16;
    logic        cin, co32, co16;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;

    hpa_adder uut (.op_a(a32), .op_b(b32), .carry_in(cin), .sum(s32), .carry_out(co32));
    hpa_adder #(.W(16)) uut16 (.op_a(a16), .op_b(b16), .carry_in(cin), .sum(s16), .carry_out(co16));

    function automatic logic [32:0] ref_add(int w, logic [31:0] a, logic [31:0] b, logic c);
        logic [63:0] t;
        logic [63:0] m;
        m = (64'd1 << w) - 64'd1;
        t = (a & m) + (b & m) + c;
        return t[32:0] & ((33'd1 << (w + 1)) - 33'd1);
    endfunction

    task automatic check(string req, logic [32:0] got, logic [32:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errs++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Apply one vector to both widths, then compare against the computed sum.
    task automatic apply(string req, logic [31:0] a, logic [31:0] b, logic c);
        @(negedge clk);
        a32 = a; b32 = b; a16 = a[15:0]; b16 = b[15:0]; cin = c;
        #1;
        check({req, " w32"}, {co32, s32}, ref_add(32, a, b, c));
        check({req, " w16"}, {16'd0, co16, s16}, ref_add(16, a, b, c));
    endtask

    task automatic t_zero();
        apply("R4 zero cin0", 32'd0, 32'd0, 1'b0);
        check("R4 zero sum w32", {co32, s32}, 33'd0);
        apply("R4 zero cin1", 32'd0, 32'd0, 1'b1);
        check("R4 zero cin1 w16", {16'd0, co16, s16}, 33'd1);
    endtask

    task automatic t_ones_plus_one();
        apply("R3 ones plus cin", 32'hFFFF_FFFF, 32'd0, 1'b1);
        check("R3 ones plus cin w32", {co32, s32}, {1'b1, 32'd0});
        check("R3 ones plus cin w16", {16'd0, co16, s16}, {16'd0, 1'b1, 16'd0});
        apply("R1 ones plus one", 32'hFFFF_FFFF, 32'd1, 1'b0);
        apply("R3 ones no cin", 32'hFFFF_FFFF, 32'd0, 1'b0);
        check("R3 ones no cin w32", {co32, s32}, {1'b0, 32'hFFFF_FFFF});
    endtask

    task automatic t_alternating();
        for (int c = 0; c < 2; c++) begin
            apply("R3 alt", 32'h5555_5555, 32'hAAAA_AAAA, c[0]);
            check("R3 alt w16", {16'd0, co16, s16}, {16'd0, c[0], {16{~c[0]}}});
        end
        apply("R1 alt same", 32'h5555_5555, 32'h5555_5555, 1'b1);
        apply("R1 alt same hi", 32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0);
    endtask

    task automatic t_double_ones();
        for (int c = 0; c < 2; c++) begin
            apply("R5 all ones", 32'hFFFF_FFFF, 32'hFFFF_FFFF, c[0]);
            check("R5 all ones w32", {co32, s32}, {1'b1, 31'h7FFF_FFFF, c[0]});
            check("R5 all ones w16", {16'd0, co16, s16}, {16'd0, 1'b1, 15'h7FFF, c[0]});
        end
    endtask

    task automatic t_msb();
        apply("R6 msb both", 32'h8000_8000, 32'h8000_8000, 1'b0);
        check("R6 cout w32", {32'd0, co32}, 33'd1);
        check("R6 cout w16", {32'd0, co16}, 33'd1);
        apply("R6 msb mixed", 32'hC123_9ABC, 32'h8765_C321, 1'b1);
        check("R6 cout mixed w32", {32'd0, co32}, 33'd1);
    endtask

    task automatic t_lsb();
        for (int v = 0; v < 8; v++) begin
            logic [31:0] ra, rb;
            ra = {$urandom, v[0]} ;
            rb = {$urandom, v[1]};
            apply("R2 lsb", ra, rb, v[2]);
            check("R2 lsb bit w32", {32'd0, s32[0]}, {32'd0, v[0] ^ v[1] ^ v[2]});
            check("R2 lsb bit w16", {32'd0, s16[0]}, {32'd0, v[0] ^ v[1] ^ v[2]});
        end
    endtask

    task automatic t_gen_sweep();
        for (int k = 0; k < 32; k++) begin
            logic [31:0] ga, gb;
            ga = 32'd1 << k;
            gb = 32'hFFFF_FFFF << k;
            apply("R7 sweep", ga, gb, 1'b0);
            check("R7 sweep w32", {co32, s32}, {1'b1, 32'd0});
            if (k < 16) check("R7 sweep w16", {16'd0, co16, s16}, {16'd0, 1'b1, 16'd0});
        end
    endtask

    task automatic t_random();
        for (int n = 0; n < 300; n++) begin
            apply("R1 random", $urandom, $urandom, 1'($urandom));
        end
    endtask

    initial begin
        a32 = '0; b32 = '0; a16 = '0; b16 = '0; cin = 1'b0;
        t_zero();
        t_ones_plus_one();
        t_alternating();
        t_double_ones();
        t_msb();
        t_lsb();
        t_gen_sweep();
        t_random();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end
endmodule